// File: doc/BRIEF.md
# Ordered Three-Button Press Detector

This block watches three push buttons and recognises when they are pressed in the order first, second, third. It is a four-state Moore machine. Each state stands for how far the operator has got through the sequence, and it drives a small LED indicator. One of three red lamps marks the progress of a sequence still underway. A single green lamp marks that the sequence is complete. Certain out-of-order presses throw the progress away and send the machine back to its starting state.

The buttons are active-low levels that the block samples on every rising clock edge. The block does no debouncing and no edge detection. A button held down over several cycles therefore acts in each of those cycles. The lamps are active-high and depend only on the current state.

The reset is active-low and asynchronous. It forces the starting state at once, without waiting for a clock edge.

Top module: `btn_seq_detect`

## Requirements
- R1: While `rst_n` is 0 the machine is in the idle state, taking effect without any clock edge; the lamps show the idle pattern both during reset and after its release until a press is acted on.
- R2: Lamp patterns, as {led_green, led_red[2:0]}: idle = 0_001, first-seen = 0_010, second-seen = 0_100, complete = 1_000; exactly one lamp is lit in every state.
- R3: A button input reads 0 when pressed and 1 when released; a 1 on a lamp output lights it.
- R4: In idle, a press of button one moves to first-seen on the next rising edge; any input with button one released keeps idle.
- R5: In first-seen, a press of button three returns to idle; otherwise a press of button two moves to second-seen; otherwise the state is kept.
- R6: In second-seen, a press of button one returns to idle; otherwise a press of button three moves to complete; otherwise the state is kept.
- R7: In complete, a press of button one or button two returns to idle; button three alone, or no press, keeps complete.
- R8: When a returning press and an advancing press occur in the same cycle, the return to idle wins.
- R9: State and lamps change only on a rising clock edge (or on reset); button changes between edges do not alter the lamps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_one_n | input | 1 | First button level, 0 = pressed |
| btn_two_n | input | 1 | Second button level, 0 = pressed |
| btn_three_n | input | 1 | Third button level, 0 = pressed |
| led_red | output | 3 | Progress lamps, bit i lit in the i-th progress state |
| led_green | output | 1 | Sequence-complete lamp |

## Verification
The assertions assume that the button levels are synchronous to `clk` and stable around each rising edge, as they would be behind a synchroniser. They also assume that the lamps are the only view of the state, so every property is written in terms of lamp patterns. The bench changes buttons only at falling edges, except for a deliberate mid-cycle change that probes R9. It asserts reset only between edges. A scripted sequence covers every transition and priority case, and a long random stream then presses each button with one-in-three probability. The random stream reaches all four states under mixed simultaneous presses.

// File: rtl/btn_seq_pkg.sv
// Package btn_seq_pkg
// Shared definitions for the ordered button detector: state type, lamp
// widths and press-vector bit positions.
package btn_seq_pkg;

    localparam int NUM_BTN  = 3;
    localparam int RED_W    = 3;
    localparam int LAMP_W   = RED_W + 1;

    // Bit positions inside the active-high press vector.
    localparam int P_ONE    = 0;
    localparam int P_TWO    = 1;
    localparam int P_THREE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_THREE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             green;
        logic [RED_W-1:0] red;
    } lamp_t;

endpackage

// File: rtl/btn_seq_next.sv
// Module btn_seq_next
// Combinational next-state rule of the detector. Takes the current state and
// an active-high press vector. Return-to-idle presses are tested before
// advancing presses, so they win when both occur together. Any state code
// outside the defined set goes to idle.
module btn_seq_next
    import btn_seq_pkg::*;
(
    input  seq_state_e              cur_state,
    input  logic [NUM_BTN-1:0]      press,
    output seq_state_e              nxt_state
);

    // Purpose: pick the following state from the current one and the presses.
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_IDLE: begin
                if (press[P_ONE])
                    nxt_state = ST_ONE;
            end
            ST_ONE: begin
                if (press[P_THREE])
                    nxt_state = ST_IDLE;
                else if (press[P_TWO])
                    nxt_state = ST_TWO;
            end
            ST_TWO: begin
                if (press[P_ONE])
                    nxt_state = ST_IDLE;
                else if (press[P_THREE])
                    nxt_state = ST_THREE;
            end
            ST_THREE: begin
                if (press[P_ONE] || press[P_TWO])
                    nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/btn_seq_state_reg.sv
// Module btn_seq_state_reg
// Holds the detector state. Assumes rst_n is an active-low asynchronous
// reset that may arrive at any time. Reset forces idle at once.
module btn_seq_state_reg
    import btn_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e nxt_state,
    output seq_state_e cur_state
);

    // Purpose: register the state, clearing to idle on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_state <= ST_IDLE;
        else
            cur_state <= nxt_state;
    end

endmodule

// File: rtl/btn_seq_lamp.sv
// Module btn_seq_lamp
// Moore output decode: maps the current state to the lamp pattern, driving
// every lamp in every state. The lamp for progress step i is generated
// per bit.
module btn_seq_lamp
    import btn_seq_pkg::*;
(
    input  seq_state_e cur_state,
    output lamp_t      lamp
);

    // Purpose: light the green lamp only in the complete state.
    always_comb begin
        lamp.green = (cur_state == ST_THREE);
    end

    for (genvar i = 0; i < RED_W; i++) begin : g_red
        // Purpose: light red lamp i only in progress state i.
        always_comb begin
            lamp.red[i] = (cur_state == seq_state_e'(i));
        end
    end

endmodule

// File: rtl/btn_seq_detect.sv
// Module btn_seq_detect
// Top of the ordered three-button detector. Assumes the button levels are
// already synchronous to clk and active-low, with no debouncing needed here.
// The lamps are combinational from the state register, so they follow reset
// without a clock.
module btn_seq_detect
    import btn_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_one_n,
    input  logic             btn_two_n,
    input  logic             btn_three_n,
    output logic [RED_W-1:0] led_red,
    output logic             led_green
);

    logic [NUM_BTN-1:0] press;
    seq_state_e         cur_state;
    seq_state_e         nxt_state;
    lamp_t              lamp;

    // Purpose: turn the active-low button levels into an active-high vector.
    always_comb begin
        press[P_ONE]   = ~btn_one_n;
        press[P_TWO]   = ~btn_two_n;
        press[P_THREE] = ~btn_three_n;
    end

    btn_seq_next u_next (
        .cur_state (cur_state),
        .press     (press),
        .nxt_state (nxt_state)
    );

    btn_seq_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    btn_seq_lamp u_lamp (
        .cur_state (cur_state),
        .lamp      (lamp)
    );

    assign led_red   = lamp.red;
    assign led_green = lamp.green;

endmodule

// File: rtl/btn_seq_detect_chk.sv
// Module btn_seq_detect_chk
// Port-level properties of the detector. The state is inferred from the lamp
// pattern. Assumes the buttons are stable around rising edges.
module btn_seq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       btn_one_n,
    input logic       btn_two_n,
    input logic       btn_three_n,
    input logic [2:0] led_red,
    input logic       led_green
);

    // R2: exactly one lamp lit at all times out of reset
    a_r2_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({led_green, led_red}));

    // R4: idle plus button one advances to first-seen
    a_r4_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b001 && !btn_one_n) |=> (led_red == 3'b010));

    // R4: idle without button one holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b001 && btn_one_n) |=> (led_red == 3'b001 && !led_green));

    // R5 and R8: button three in first-seen returns to idle
    a_r5_one_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b010 && !btn_three_n) |=> (led_red == 3'b001));

    // R5: button two alone in first-seen advances
    a_r5_one_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b010 && !btn_two_n && btn_three_n) |=> (led_red == 3'b100));

    // R6 and R8: button one in second-seen returns to idle
    a_r6_two_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b100 && !btn_one_n) |=> (led_red == 3'b001));

    // R6: button three without button one completes
    a_r6_two_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (led_red == 3'b100 && btn_one_n && !btn_three_n) |=> led_green);

    // R7: button one or two in complete returns to idle
    a_r7_three_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (led_green && (!btn_one_n || !btn_two_n)) |=> (led_red == 3'b001));

    // R7: complete holds with buttons one and two released
    a_r7_three_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (led_green && btn_one_n && btn_two_n) |=> $stable(led_green));

    // R1: during reset the idle pattern is shown
    always @(negedge clk) begin
        if (!rst_n)
            a_r1_reset_idle: assert ({led_green, led_red} == 4'b0001);
    end

endmodule

bind btn_seq_detect btn_seq_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_one_n   (btn_one_n),
    .btn_two_n   (btn_two_n),
    .btn_three_n (btn_three_n),
    .led_red     (led_red),
    .led_green   (led_green)
);

// File: tb/btn_seq_detect_tb.sv
module btn_seq_detect_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b1_n = 1'b1, b2_n = 1'b1, b3_n = 1'b1;
    logic [2:0] led_red;
    logic       led_green;

    int total = 0;
    int bad = 0;
    int model_st = 0;   // 0 idle, 1 first, 2 second, 3 complete
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_seq_detect u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_one_n   (b1_n),
        .btn_two_n   (b2_n),
        .btn_three_n (b3_n),
        .led_red     (led_red),
        .led_green   (led_green)
    );

    function automatic logic [3:0] lamp_of(int st);
        case (st)
            0: return 4'b0001;
            1: return 4'b0010;
            2: return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic int step_model(int st, bit p1, bit p2, bit p3);
        if (st == 0) return p1 ? 1 : 0;
        if (st == 1) return p3 ? 0 : (p2 ? 2 : 1);
        if (st == 2) return p1 ? 0 : (p3 ? 3 : 2);
        return (p1 || p2) ? 0 : 3;
    endfunction

    task automatic check(string req);
        logic [3:0] got;
        got = {led_green, led_red};
        total++;
        if (got !== lamp_of(model_st)) begin
            bad++;
            $display("FAIL %s: lamps got=%b expected=%b", req, got, lamp_of(model_st));
        end
    endtask

    // One cycle: check at falling edge, drive presses, update model at rising edge.
    task automatic cyc(bit p1, bit p2, bit p3, string req);
        @(negedge clk);
        check(req);
        b1_n = ~p1; b2_n = ~p2; b3_n = ~p3;
        @(posedge clk);
        model_st = step_model(model_st, p1, p2, p3);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");
        // R3/R4: idle holds without button one
        cyc(0, 1, 1, "R4");
        cyc(1, 0, 0, "R4");
        // R5: first-seen holds on no press, advances on two
        cyc(0, 0, 0, "R5");
        cyc(0, 1, 0, "R5");
        // R6: second-seen holds on button two, then completes
        cyc(0, 1, 0, "R6");
        cyc(0, 0, 1, "R6");
        // R7: complete holds on button three
        cyc(0, 0, 1, "R7");
        cyc(0, 0, 0, "R7");
        cyc(0, 1, 0, "R7");
        // R5/R8: three beats two in first-seen
        cyc(1, 0, 0, "R5");
        cyc(0, 1, 1, "R8");
        // R6/R8: one beats three in second-seen
        cyc(1, 0, 0, "R6");
        cyc(0, 1, 0, "R6");
        cyc(1, 0, 1, "R8");
        // R7: button one in complete
        cyc(1, 0, 0, "R7");
        cyc(0, 1, 0, "R7");
        cyc(0, 0, 1, "R7");
        cyc(1, 0, 1, "R7");
        cyc(0, 0, 0, "R8");
        // R9: mid-cycle press has no effect before the edge
        @(negedge clk);
        check("R9");
        b1_n = 1'b0;
        #(CLK_PERIOD/4);
        check("R9");
        @(posedge clk);
        model_st = step_model(model_st, 1, 0, 0);
        cyc(0, 1, 0, "R9");
        // R1: asynchronous reset from second-seen, no clock edge needed
        @(negedge clk);
        check("R1");
        b1_n = 1'b1; b2_n = 1'b1; b3_n = 1'b1;
        #1 rst_n = 1'b0;
        #1 model_st = 0;
        check("R1");
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");
        // Random stream, compared against the model every cycle
        for (int i = 0; i < 2000; i++) begin
            cyc($urandom_range(2) == 0, $urandom_range(2) == 0,
                $urandom_range(2) == 0, "R2");
        end
        @(negedge clk);
        check("R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule